// File: doc/BRIEF.md
# Serial Access Register Port

This block is the serial side of a dual-ported memory. It holds one full row of bytes in a register file. A single strobe can fill the whole row from a wide parallel bus, and the whole row is always visible on a second wide bus so the transfer logic can write it back. A serial step strobe moves one byte in or out at an internal pointer and then advances the pointer by one. The pointer wraps at the end of the row.

The transfer logic starts every transfer with `xfer_go` and its type code. The type sets the pointer to the tap address given with the transfer, and it also sets the direction of the serial port. A read transfer loads the row and turns the port to output. A write transfer or a pseudo-write transfer turns the port to input. No pin sets the direction directly.

The active-low serial enable gates only the data movement. The pointer advances on every accepted step, whether the enable is active or not. A serial step that arrives while a transfer is in progress is dropped and flagged.

Top module: `sar_port`

## Requirements
- R1: Each accepted `ser_step` moves one byte at the current pointer and then increments the pointer by one.
- R2: The pointer wraps from DEPTH-1 to 0.
- R3: A transfer (`xfer_go` high) sets the pointer to `xfer_tap`. The next accepted step uses that address.
- R4: While `ser_en_n` is high, a step moves no data. `ser_dvalid` goes to 0 and the stored bytes stay unchanged, but the pointer still advances.
- R5: In output mode, a step with `ser_en_n` low puts the byte at the pointer on `ser_dout` and sets `ser_dvalid` to 1. Both appear in the cycle after the step.
- R6: In input mode, a step with `ser_en_n` low writes `ser_din` into the byte at the pointer. `ser_dvalid` stays 0 in input mode.
- R7: `xfer_kind` 2'b00 is a read transfer. It loads `row_in` into the register (byte i from bits i*WIDTH upward) and selects output mode (`ser_in_mode`=0). Code 2'b01 (write) and codes 2'b10 and 2'b11 (pseudo write) select input mode (`ser_in_mode`=1).
- R8: A write transfer raises `row_dump` for exactly one cycle, in the cycle after `xfer_go`. During that cycle `row_out` carries the register contents (byte i at bits i*WIDTH upward).
- R9: A pseudo-write transfer does not raise `row_dump` and leaves the stored bytes unchanged.
- R10: After reset, the port is in input mode, and `ser_dvalid`, `row_dump` and `proto_err` are 0.
- R11: A step while `xfer_busy` is high is ignored, with no data movement and no pointer change. `proto_err` pulses high in the following cycle.
- R12: A step in the same cycle as `xfer_go` loses to the transfer. The transfer takes full effect, the step is dropped, and `proto_err` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_go | input | 1 | Transfer strobe |
| xfer_kind | input | 2 | Transfer type: 00 read, 01 write, 1x pseudo write |
| xfer_tap | input | PTR_W | Start pointer for the transfer |
| xfer_busy | input | 1 | Transfer in progress; serial steps are refused |
| row_in | input | DEPTH*WIDTH | Row data loaded by a read transfer |
| row_out | output | DEPTH*WIDTH | Current register contents |
| row_dump | output | 1 | One-cycle pulse after a write transfer |
| ser_step | input | 1 | Serial clock edge strobe |
| ser_en_n | input | 1 | Active-low serial enable |
| ser_din | input | WIDTH | Serial input byte |
| ser_dout | output | WIDTH | Serial output byte |
| ser_dvalid | output | 1 | ser_dout holds a byte read by the last step |
| ser_in_mode | output | 1 | 1 = input mode, 0 = output mode |
| proto_err | output | 1 | Pulse: a step was refused during a transfer |

## Verification
The bench builds the block with DEPTH=16 and WIDTH=8. With a 16-byte row, a tap of 14 reaches the wrap from 15 to 0 after only two steps. The whole row can also be compared through `row_out` against a model built in the bench. The default DEPTH of 256 would need hundreds of steps per wrap and gives no extra coverage.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    XF_READ   = 2'b00,
    XF_WRITE  = 2'b01,
    XF_PSEUDO = 2'b10
  } xfer_e;

  function automatic xfer_e decode_kind(input logic [1:0] code);
    if (code == 2'b00)      return XF_READ;
    else if (code == 2'b01) return XF_WRITE;
    else                    return XF_PSEUDO;
  endfunction
endpackage

// File: rtl/sar_ptr.sv
module sar_ptr #(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] tap,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | adv;
    ptr_d  = load ? tap : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr_q == PTR_W'(DEPTH-1)) |=> ptr_q == '0);
  // R3
  ptr_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr_q == $past(tap));
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ptr_q));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_go,
  input  logic [1:0] xfer_kind,
  input  logic       xfer_busy,
  input  logic       ser_step,
  input  logic       ser_en_n,
  output logic       step_ok,
  output logic       load_row,
  output logic       wr_en,
  output logic       rd_en,
  output logic       in_mode,
  output logic       dump,
  output logic       err
);
  xfer_e kind;
  logic  in_mode_q, in_mode_d;
  logic  dump_q, dump_d;
  logic  err_q, err_d;

  always_comb begin
    kind      = decode_kind(xfer_kind);
    step_ok   = ser_step & ~xfer_busy & ~xfer_go;
    load_row  = xfer_go & (kind == XF_READ);
    wr_en     = step_ok & in_mode_q & ~ser_en_n;
    rd_en     = step_ok & ~in_mode_q & ~ser_en_n;
    in_mode_d = xfer_go ? (kind != XF_READ) : in_mode_q;
    dump_d    = xfer_go & (kind == XF_WRITE);
    err_d     = ser_step & (xfer_busy | xfer_go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mode_q <= 1'b1;
      dump_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      in_mode_q <= in_mode_d;
      dump_q    <= dump_d;
      err_q     <= err_d;
    end
  end

  assign in_mode = in_mode_q;
  assign dump    = dump_q;
  assign err     = err_q;

  // R7
  mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_kind == 2'b00) |=> !in_mode_q);
  // R7
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_kind != 2'b00) |=> in_mode_q);
  // R8
  dump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q);
  // R11
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_step && xfer_busy) |=> err_q);
  // R6
  no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: rtl/sar_store.sv
module sar_store #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_row,
  input  logic [DEPTH*WIDTH-1:0] row_in,
  output logic [DEPTH*WIDTH-1:0] row_out,
  input  logic [PTR_W-1:0]       ptr,
  input  logic                   step_ok,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   clr_valid,
  input  logic [WIDTH-1:0]       din,
  output logic [WIDTH-1:0]       dout,
  output logic                   dvalid
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] dout_q, dout_d;
  logic             dvalid_q, dvalid_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WIDTH-1:0] cell_d;
    logic             cell_en;
    always_comb begin
      cell_en = load_row | (wr_en && ptr == PTR_W'(i));
      cell_d  = load_row ? row_in[i*WIDTH +: WIDTH] : din;
    end
    always_ff @(posedge clk) begin
      if (cell_en) mem_q[i] <= cell_d;
    end
    assign row_out[i*WIDTH +: WIDTH] = mem_q[i];
  end

  always_comb begin
    dout_d   = rd_en ? mem_q[ptr] : dout_q;
    dvalid_d = clr_valid ? 1'b0 : (step_ok ? rd_en : dvalid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dout_q   <= dout_d;
      dvalid_q <= dvalid_d;
    end
  end

  assign dout   = dout_q;
  assign dvalid = dvalid_q;

  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !clr_valid) |=> dvalid_q);
  // R4
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ok && !clr_valid) |=> ($stable(dvalid_q) && $stable(dout_q)));
endmodule

// File: rtl/sar_port.sv
module sar_port #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xfer_go,
  input  logic [1:0]             xfer_kind,
  input  logic [PTR_W-1:0]       xfer_tap,
  input  logic                   xfer_busy,
  input  logic [DEPTH*WIDTH-1:0] row_in,
  output logic [DEPTH*WIDTH-1:0] row_out,
  output logic                   row_dump,
  input  logic                   ser_step,
  input  logic                   ser_en_n,
  input  logic [WIDTH-1:0]       ser_din,
  output logic [WIDTH-1:0]       ser_dout,
  output logic                   ser_dvalid,
  output logic                   ser_in_mode,
  output logic                   proto_err
);
  logic             step_ok, load_row, wr_en, rd_en;
  logic [PTR_W-1:0] ptr;

  sar_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_go   (xfer_go),
    .xfer_kind (xfer_kind),
    .xfer_busy (xfer_busy),
    .ser_step  (ser_step),
    .ser_en_n  (ser_en_n),
    .step_ok   (step_ok),
    .load_row  (load_row),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .in_mode   (ser_in_mode),
    .dump      (row_dump),
    .err       (proto_err)
  );

  sar_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (xfer_go),
    .tap   (xfer_tap),
    .adv   (step_ok),
    .ptr   (ptr)
  );

  sar_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_row  (load_row),
    .row_in    (row_in),
    .row_out   (row_out),
    .ptr       (ptr),
    .step_ok   (step_ok),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .clr_valid (xfer_go),
    .din       (ser_din),
    .dout      (ser_dout),
    .dvalid    (ser_dvalid)
  );

  // R6
  in_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_in_mode |-> !ser_dvalid);
  // R12
  go_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && ser_step) |=> proto_err);
endmodule

// File: tb/tb_sar_port.sv
`timescale 1ns/1ps
module tb_sar_port;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int PW    = $clog2(DEPTH);

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   xfer_go, xfer_busy, ser_step, ser_en_n;
  logic [1:0]             xfer_kind;
  logic [PW-1:0]          xfer_tap;
  logic [DEPTH*WIDTH-1:0] row_in, row_out;
  logic                   row_dump, ser_dvalid, ser_in_mode, proto_err;
  logic [WIDTH-1:0]       ser_din, ser_dout;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] pat  [DEPTH];
  logic [WIDTH-1:0] pat2 [DEPTH];

  always #5 clk = ~clk;

  sar_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_kind(xfer_kind),
    .xfer_tap(xfer_tap), .xfer_busy(xfer_busy), .row_in(row_in),
    .row_out(row_out), .row_dump(row_dump), .ser_step(ser_step),
    .ser_en_n(ser_en_n), .ser_din(ser_din), .ser_dout(ser_dout),
    .ser_dvalid(ser_dvalid), .ser_in_mode(ser_in_mode), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    xfer_go = 0; ser_step = 0; xfer_busy = 0;
  endtask

  function automatic logic [WIDTH-1:0] rbyte(input int i);
    return row_out[i*WIDTH +: WIDTH];
  endfunction

  task automatic step(input logic en_n, input logic [WIDTH-1:0] d);
    ser_step = 1; ser_en_n = en_n; ser_din = d;
    tick();
    ser_step = 0; ser_en_n = 1;
  endtask

  task automatic xfer(input logic [1:0] k, input logic [PW-1:0] tap);
    xfer_go = 1; xfer_kind = k; xfer_tap = tap;
    tick();
    xfer_go = 0;
  endtask

  task automatic t_reset();
    chk(ser_in_mode === 1'b1, "R10 mode", ser_in_mode, 1);
    chk(ser_dvalid === 1'b0 && row_dump === 1'b0 && proto_err === 1'b0,
        "R10 flags", {ser_dvalid, row_dump, proto_err}, 0);
  endtask

  task automatic t_read();
    for (int i = 0; i < DEPTH; i++) row_in[i*WIDTH +: WIDTH] = pat[i];
    xfer(2'b00, PW'(14));
    chk(ser_in_mode === 1'b0, "R7 read mode", ser_in_mode, 0);
    chk(row_out === row_in, "R7 row load", 0, 1);
    step(0, 0);
    chk(ser_dvalid === 1 && ser_dout === pat[14], "R3 R5 tap byte", ser_dout, pat[14]);
    step(0, 0);
    chk(ser_dout === pat[15], "R1 next byte", ser_dout, pat[15]);
    step(0, 0);
    chk(ser_dout === pat[0], "R2 wrap", ser_dout, pat[0]);
    step(1, 0);
    chk(ser_dvalid === 1'b0, "R4 no output", ser_dvalid, 0);
    step(0, 0);
    chk(ser_dout === pat[2] && ser_dvalid === 1, "R4 pointer advanced", ser_dout, pat[2]);
  endtask

  task automatic t_pseudo();
    xfer(2'b10, PW'(3));
    chk(ser_in_mode === 1'b1 && ser_dvalid === 1'b0, "R7 pseudo mode", ser_in_mode, 1);
    chk(row_dump === 1'b0, "R9 no dump", row_dump, 0);
    chk(row_out === row_in, "R9 contents kept", 0, 1);
    step(0, 8'h11);
    chk(ser_dvalid === 1'b0, "R6 no valid in input", ser_dvalid, 0);
    step(0, 8'h22);
    step(1, 8'hEE);
    step(0, 8'h33);
    chk(rbyte(3) === 8'h11 && rbyte(4) === 8'h22, "R6 serial write", rbyte(4), 8'h22);
    chk(rbyte(5) === pat[5], "R4 disabled write", rbyte(5), pat[5]);
    chk(rbyte(6) === 8'h33, "R4 R6 pointer advanced", rbyte(6), 8'h33);
  endtask

  task automatic t_write();
    xfer(2'b01, PW'(0));
    chk(row_dump === 1'b1 && ser_in_mode === 1'b1, "R8 dump pulse", row_dump, 1);
    chk(rbyte(3) === 8'h11, "R8 dump data", rbyte(3), 8'h11);
    tick();
    chk(row_dump === 1'b0, "R8 single cycle", row_dump, 0);
  endtask

  task automatic t_busy();
    xfer_busy = 1;
    step(0, 8'h55);
    xfer_busy = 0;
    chk(proto_err === 1'b1, "R11 error", proto_err, 1);
    chk(rbyte(0) === pat[0], "R11 no write", rbyte(0), pat[0]);
    step(0, 8'h66);
    chk(proto_err === 1'b0, "R11 error clears", proto_err, 0);
    chk(rbyte(0) === 8'h66, "R11 pointer held", rbyte(0), 8'h66);
  endtask

  task automatic t_collide();
    for (int i = 0; i < DEPTH; i++) row_in[i*WIDTH +: WIDTH] = pat2[i];
    xfer_go = 1; xfer_kind = 2'b00; xfer_tap = PW'(8);
    ser_step = 1; ser_en_n = 0; ser_din = 8'h77;
    tick();
    idle(); ser_en_n = 1;
    chk(proto_err === 1'b1, "R12 error", proto_err, 1);
    chk(ser_in_mode === 1'b0 && rbyte(1) === pat2[1], "R12 load wins", rbyte(1), pat2[1]);
    step(0, 0);
    chk(ser_dout === pat2[8], "R12 tap used", ser_dout, pat2[8]);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      pat[i]  = 8'(8'hA0 ^ (i * 7));
      pat2[i] = 8'(8'h3C + i * 13);
    end
    idle(); ser_en_n = 1; ser_din = 0; xfer_kind = 0; xfer_tap = 0; row_in = '0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_read();
    t_pseudo();
    t_write();
    t_busy();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule